// File: doc/BRIEF.md
# Low-Power Clock Controller

This block holds one control byte for a small microcontroller and turns it into the clock enables for the rest of the chip. Software uses the byte to switch each of the two oscillators on or off, to pick the system clock, and to enter two idle-type modes. The system clock is either the geared high-frequency clock or the low-frequency clock divided by four. One idle mode stops the CPU and the watchdog. The other stops the timing-generator clock to every peripheral except the time-base timer. A wake-up event ends either mode, and the halt bit that started it clears itself.

Both source clocks reach the block as single-cycle enable strobes in one reference clock domain, so every output is a clock enable. When software changes the clock source, the system clock stops completely for a fixed drain window and then restarts from the new source. This avoids a partial pulse at the changeover. A write that tries to set both halt bits in one go is illegal. The block drops the halt part of such a write and still applies the rest of the byte.

Top module: `lpc_clock_ctrl`

## Requirements
- R1: After reset the control byte reads 0x40, `hosc_en_o` is 1 and `losc_en_o` is 0. Bits 7, 1 and 0 always read 0, even after a write of 1s to them.
- R2: A write stores wdata bit 6 as high-oscillator enable, bit 5 as low-oscillator enable, bit 4 as clock select (1 = slow), bit 3 as CPU/watchdog halt and bit 2 as peripheral halt. The new value reads back in the cycle after the write.
- R3: `hosc_en_o` follows control bit 6 and `losc_en_o` follows control bit 5 from the cycle after the write.
- R4: With select 0, every `gear_tick_i` strobe yields a system tick on `tbt_ce_o` in the same cycle. With select 1, exactly one system tick is produced per four `lf_tick_i` strobes.
- R5: After the select bit changes, no system tick is produced for DRAIN_CYC+1 cycles. Only then does the new source drive the system tick.
- R6: While control bit 3 is set, `cpu_ce_o` and `wdt_ce_o` stay 0 from the cycle after the write. `tbt_ce_o` and `periph_ce_o` keep running.
- R7: While control bit 2 is set, `periph_ce_o` stays 0. `tbt_ce_o` and `cpu_ce_o` keep ticking.
- R8: `wake_i` is registered once. On the next edge it clears both halt bits and leaves the other fields unchanged. A wake with no halt bit set has no effect.
- R9: A write with wdata bits 3 and 2 both 1 leaves both halt bits at their previous values and updates bits 6..4. The two halt bits are never both 1.
- R10: `stage9_lf_o` is 1 exactly while the slow clock is the active system clock source, including low-frequency sleep (select 1 with halt bit 3 set).
- R11: If a halt release from wake and a register write happen on the same edge, the halt bits end cleared and bits 6..4 take the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| gear_tick_i | input | 1 | Enable strobe of the geared high-frequency clock |
| lf_tick_i | input | 1 | Enable strobe of the low-frequency clock |
| wr_en_i | input | 1 | Control byte write strobe |
| wdata_i | input | 8 | Control byte write data |
| rdata_o | output | 8 | Control byte read data |
| wake_i | input | 1 | Wake-up event |
| hosc_en_o | output | 1 | High-frequency oscillator enable |
| losc_en_o | output | 1 | Low-frequency oscillator enable |
| cpu_ce_o | output | 1 | CPU clock enable |
| wdt_ce_o | output | 1 | Watchdog clock enable |
| periph_ce_o | output | 1 | Timing-generator clock enable to peripherals |
| tbt_ce_o | output | 1 | Time-base timer clock enable (the raw system tick) |
| stage9_lf_o | output | 1 | Divider stage-9 input taken from the low clock / 4 |

## Verification
The wake-up release and a software write can both change the halt fields on the same edge. The bench sets the CPU halt and pulses `wake_i`. It then issues a write in exactly the cycle where the registered wake performs the release, and that write tries to set the halt bit again while also turning on the low oscillator. The readback must show the halt bits cleared and the low-oscillator bit set. This shows that the release wins over the halt fields while the other fields still take the write.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int CTRL_W      = 8;
    localparam int HOSC_POS    = 6;
    localparam int LOSC_POS    = 5;
    localparam int SEL_POS     = 4;
    localparam int HALT_CPU_POS = 3;
    localparam int HALT_TG_POS  = 2;

    typedef struct packed {
        logic hosc;
        logic losc;
        logic sel_slow;
        logic halt_cpu;
        logic halt_tg;
    } lpc_ctrl_t;

    localparam lpc_ctrl_t CTRL_RESET = '{hosc: 1'b1, losc: 1'b0, sel_slow: 1'b0,
                                         halt_cpu: 1'b0, halt_tg: 1'b0};

    typedef enum logic [0:0] {
        SW_RUN   = 1'b0,
        SW_DRAIN = 1'b1
    } sw_state_e;

    function automatic logic [CTRL_W-1:0] ctrl_to_byte(input lpc_ctrl_t c);
        logic [CTRL_W-1:0] b;
        b               = '0;
        b[HOSC_POS]     = c.hosc;
        b[LOSC_POS]     = c.losc;
        b[SEL_POS]      = c.sel_slow;
        b[HALT_CPU_POS] = c.halt_cpu;
        b[HALT_TG_POS]  = c.halt_tg;
        return b;
    endfunction

endpackage

// File: rtl/lpc_ctrl_reg.sv
module lpc_ctrl_reg
    import lpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              wake_i,
    output lpc_ctrl_t         ctrl_o,
    output logic [CTRL_W-1:0] rdata_o
);

    typedef struct packed {
        lpc_ctrl_t ctrl;
        logic      wake;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       both_halt_w;
    logic       release_w;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata_i[CTRL_W-1], wdata_i[1:0]};

    always_comb begin
        st_d        = st_q;
        st_d.wake   = wake_i;
        both_halt_w = wdata_i[HALT_CPU_POS] & wdata_i[HALT_TG_POS];
        release_w   = st_q.wake & (st_q.ctrl.halt_cpu | st_q.ctrl.halt_tg);

        if (wr_en_i) begin
            st_d.ctrl.hosc     = wdata_i[HOSC_POS];
            st_d.ctrl.losc     = wdata_i[LOSC_POS];
            st_d.ctrl.sel_slow = wdata_i[SEL_POS];
            if (!both_halt_w) begin
                st_d.ctrl.halt_cpu = wdata_i[HALT_CPU_POS];
                st_d.ctrl.halt_tg  = wdata_i[HALT_TG_POS];
            end
        end

        // wake-up release overrides any halt value written on the same edge
        if (release_w) begin
            st_d.ctrl.halt_cpu = 1'b0;
            st_d.ctrl.halt_tg  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RESET;
            st_q.wake <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign rdata_o = ctrl_to_byte(st_q.ctrl);

    assert_halt_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ctrl.halt_cpu && st_q.ctrl.halt_tg));

    assert_wake_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake && (st_q.ctrl.halt_cpu || st_q.ctrl.halt_tg))
        |=> (!st_q.ctrl.halt_cpu && !st_q.ctrl.halt_tg));

    assert_release_keeps_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake && !wr_en_i) |=> (st_q.ctrl.hosc == $past(st_q.ctrl.hosc)
                                     && st_q.ctrl.sel_slow == $past(st_q.ctrl.sel_slow)));

endmodule

// File: rtl/lpc_lf_div.sv
module lpc_lf_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic tick_o
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.cnt == CNT_LAST) st_d.cnt = '0;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign tick_o = tick_i & (st_q.cnt == CNT_LAST);

    assert_div_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/lpc_clk_switch.sv
module lpc_clk_switch
    import lpc_pkg::*;
#(
    parameter int DRAIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_slow_i,
    input  logic gear_tick_i,
    input  logic slow_tick_i,
    output logic sys_tick_o,
    output logic cur_slow_o
);

    localparam int CNT_W = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYC - 1);

    typedef struct packed {
        sw_state_e        state;
        logic             cur_slow;
        logic [CNT_W-1:0] cnt;
    } sw_t;

    sw_t  st_d, st_q;
    logic src_tick_w;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SW_RUN: begin
                if (req_slow_i != st_q.cur_slow) begin
                    st_d.state = SW_DRAIN;
                    st_d.cnt   = '0;
                end
            end
            SW_DRAIN: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.state    = SW_RUN;
                    st_d.cur_slow = req_slow_i;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.state = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state    <= SW_RUN;
            st_q.cur_slow <= 1'b0;
            st_q.cnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_tick_w = st_q.cur_slow ? slow_tick_i : gear_tick_i;
    // old gate drops as soon as the request differs, new gate opens after drain
    assign sys_tick_o = (st_q.state == SW_RUN) & (req_slow_i == st_q.cur_slow) & src_tick_w;
    assign cur_slow_o = st_q.cur_slow;

    assert_switch_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur_slow != $past(st_q.cur_slow)) |-> ($past(st_q.state) == SW_DRAIN));

    assert_drain_leaves_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SW_RUN && req_slow_i != st_q.cur_slow) |=> (st_q.state == SW_DRAIN));

endmodule

// File: rtl/lpc_clock_ctrl.sv
module lpc_clock_ctrl
    import lpc_pkg::*;
#(
    parameter int LF_DIV    = 4,
    parameter int DRAIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gear_tick_i,
    input  logic              lf_tick_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] rdata_o,
    input  logic              wake_i,
    output logic              hosc_en_o,
    output logic              losc_en_o,
    output logic              cpu_ce_o,
    output logic              wdt_ce_o,
    output logic              periph_ce_o,
    output logic              tbt_ce_o,
    output logic              stage9_lf_o
);

    lpc_ctrl_t ctrl_w;
    logic      slow_tick_w;
    logic      sys_tick_w;
    logic      cur_slow_w;

    lpc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .wake_i  (wake_i),
        .ctrl_o  (ctrl_w),
        .rdata_o (rdata_o)
    );

    lpc_lf_div #(.DIV(LF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (lf_tick_i),
        .tick_o (slow_tick_w)
    );

    lpc_clk_switch #(.DRAIN_CYC(DRAIN_CYC)) u_sw (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_slow_i  (ctrl_w.sel_slow),
        .gear_tick_i (gear_tick_i),
        .slow_tick_i (slow_tick_w),
        .sys_tick_o  (sys_tick_w),
        .cur_slow_o  (cur_slow_w)
    );

    assign hosc_en_o   = ctrl_w.hosc;
    assign losc_en_o   = ctrl_w.losc;
    assign tbt_ce_o    = sys_tick_w;
    assign cpu_ce_o    = sys_tick_w & ~ctrl_w.halt_cpu;
    assign wdt_ce_o    = sys_tick_w & ~ctrl_w.halt_cpu;
    assign periph_ce_o = sys_tick_w & ~ctrl_w.halt_tg;
    assign stage9_lf_o = cur_slow_w;

    assert_cpu_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[HALT_CPU_POS] |-> (!cpu_ce_o && !wdt_ce_o));

    assert_tbt_covers_periph_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ce_o |-> tbt_ce_o);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[CTRL_W-1] == 1'b0) && (rdata_o[1:0] == 2'b00));

endmodule

// File: tb/sim_lpc_clock_ctrl.sv
`timescale 1ns/1ps
module sim_lpc_clock_ctrl;

    localparam int DRAIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gear_tick = 1'b0;
    logic       lf_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       wake = 1'b0;
    logic       hosc_en, losc_en, cpu_ce, wdt_ce, periph_ce, tbt_ce, stage9_lf;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    lpc_clock_ctrl #(.LF_DIV(4), .DRAIN_CYC(DRAIN)) u0 (
        .clk(clk), .rst_n(rst_n), .gear_tick_i(gear_tick), .lf_tick_i(lf_tick),
        .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .wake_i(wake),
        .hosc_en_o(hosc_en), .losc_en_o(losc_en), .cpu_ce_o(cpu_ce), .wdt_ce_o(wdt_ce),
        .periph_ce_o(periph_ce), .tbt_ce_o(tbt_ce), .stage9_lf_o(stage9_lf)
    );

    // source strobes change shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc       = cyc + 1;
            gear_tick = cyc[0];
            lf_tick   = (cyc % 5 == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wdata = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset rdata", rdata, 8'h40);
        chk("R1 reset hosc", hosc_en, 1);
        chk("R1 reset losc", losc_en, 0);
        wr(8'hC3);
        chk("R1 reserved bits read 0", rdata, 8'h40);
    endtask

    task automatic t_fields();
        wr(8'h20);
        chk("R2 readback 0x20", rdata, 8'h20);
        chk("R3 hosc off", hosc_en, 0);
        chk("R3 losc on", losc_en, 1);
        wr(8'h60);
        chk("R2 readback 0x60", rdata, 8'h60);
        chk("R3 hosc on", hosc_en, 1);
    endtask

    task automatic t_gear();
        int miss = 0;
        int seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tbt_ce != gear_tick || cpu_ce != gear_tick || periph_ce != gear_tick) miss++;
            seen += tbt_ce;
        end
        chk("R4 gear tick follows strobe", miss, 0);
        chk("R4 gear ticks seen", seen, 6);
        chk("R10 stage9 off in gear", stage9_lf, 0);
    endtask

    task automatic t_halt_cpu();
        int cpu_n = 0;
        int tbt_n = 0;
        int per_n = 0;
        wr(8'h48);
        for (int i = 0; i < 10; i++) begin
            cpu_n += cpu_ce; cpu_n += wdt_ce; tbt_n += tbt_ce; per_n += periph_ce;
            @(negedge clk);
        end
        chk("R6 cpu/wdt stopped", cpu_n, 0);
        chk("R6 tbt keeps running", tbt_n, 5);
        chk("R6 periph keeps running", per_n, 5);
        pulse_wake();
        chk("R8 halt still set one cycle after wake", rdata, 8'h48);
        @(negedge clk);
        chk("R8 halt cleared, fields kept", rdata, 8'h40);
    endtask

    task automatic t_halt_tg();
        int cpu_n = 0;
        int tbt_n = 0;
        int per_n = 0;
        wr(8'h44);
        for (int i = 0; i < 10; i++) begin
            cpu_n += cpu_ce; tbt_n += tbt_ce; per_n += periph_ce;
            @(negedge clk);
        end
        chk("R7 periph stopped", per_n, 0);
        chk("R7 tbt runs", tbt_n, 5);
        chk("R7 cpu runs", cpu_n, 5);
        // illegal double halt leaves halts, updates upper fields
        wr(8'h2C);
        chk("R9 both-halt write keeps halts", rdata, 8'h24);
        pulse_wake();
        @(negedge clk);
        chk("R8 peripheral halt cleared", rdata, 8'h20);
        wr(8'h6C);
        chk("R9 both-halt from idle", rdata, 8'h60);
    endtask

    task automatic t_wake_idle();
        wr(8'h40);
        pulse_wake();
        @(negedge clk);
        chk("R8 wake without halt no effect", rdata, 8'h40);
    endtask

    task automatic t_same_cycle();
        wr(8'h48);
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0; wr_en = 1'b1; wdata = 8'h68;
        @(negedge clk); wr_en = 1'b0;
        chk("R11 release beats write on halt", rdata, 8'h60);
    endtask

    task automatic t_slow();
        int hit = 0;
        int n = 0;
        int cpu_n = 0;
        wr(8'h70);
        for (int i = 0; i <= DRAIN; i++) begin
            hit += tbt_ce; hit += stage9_lf;
            @(negedge clk);
        end
        chk("R5 quiet during drain", hit, 0);
        chk("R10 stage9 on after drain", stage9_lf, 1);
        for (int i = 0; i < 200; i++) begin
            n += tbt_ce;
            @(negedge clk);
        end
        chk("R4 one tick per four slow strobes", n, 10);
        wr(8'h78);
        for (int i = 0; i < 40; i++) begin
            cpu_n += cpu_ce;
            @(negedge clk);
        end
        chk("R6 cpu stopped in slow sleep", cpu_n, 0);
        chk("R10 stage9 on in slow sleep", stage9_lf, 1);
        pulse_wake();
        @(negedge clk);
        chk("R8 sleep released", rdata, 8'h70);
        wr(8'h60);
        hit = 0;
        for (int i = 0; i <= DRAIN; i++) begin
            hit += tbt_ce;
            @(negedge clk);
        end
        chk("R5 quiet during drain back", hit, 0);
        chk("R10 stage9 off after return", stage9_lf, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        wr(8'h40);
        t_gear();
        t_halt_cpu();
        t_halt_tg();
        t_wake_idle();
        t_same_cycle();
        t_slow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule